// File: doc/BRIEF.md
# Integer and Fractional 8x8 Multiplier

This block forms the 16-bit product of two 8-bit operands for a processor datapath whose multiply results always go to one fixed register pair: the upper byte of the output feeds the higher register of that pair, the lower byte feeds the lower one. A two-bit mode input sets how each operand is read. Both can be unsigned, both can be two's complement, or the first operand (Rd) can be signed while the second (Rr) is unsigned. A fractional input is meant for 1.7 fixed-point operands. When it is set, the block moves the product one place to the left before it presents the result.

Each operation takes two cycles from a one-cycle start strobe to a one-cycle done pulse. The block updates two flag values with every result: a zero indication and a carry. The carry is taken from the product before any fractional scaling. The result and the flags stay on the outputs until the next operation completes. A start that arrives while an operation is in flight is dropped. Writeback into the register file and any checking of which registers may be named are left to the surrounding core.

Top module: `mul8_frac_unit`

## Requirements
- R1: With mode code 0 both operands are read as unsigned, and the product output equals rd_i times rr_i. For example 0xFF x 0xFF gives 0xFE01.
- R2: With mode code 1 both operands are read as two's complement, and the product output is their signed product in 16 bits. For example 0x80 x 0x80 (-128 x -128) gives 0x4000.
- R3: With mode code 2, rd_i is read as two's complement and rr_i as unsigned. For example 0xFF x 0xFF gives 0xFF01 (-255).
- R4: Mode code 3 produces the same result and flags as mode code 0.
- R5: When frac_i is 1 at start, the product output is the 16-bit product moved left by one bit with a zero in bit 0. The top bit is lost without saturation, so signed 0x80 x 0x80 gives 0x8000.
- R6: c_o equals bit 15 of the 16-bit product before any fractional shift.
- R7: z_o is 1 exactly when the final 16-bit product output (after any shift) is zero.
- R8: done_o is high for exactly one cycle, two cycles after the cycle in which an accepted start_i was high. The new product and flags appear in that same cycle.
- R9: A start_i that is high in the cycle right after an accepted start is ignored. It produces no extra done pulse, and it does not alter the result of the operation in flight.
- R10: Between done pulses, the product output and both flags hold their last values.
- R11: After reset, the product output is 0, both flags are 0 and done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a multiply |
| mode_i | input | 2 | Signedness: 0 unsigned x unsigned, 1 signed x signed, 2 signed Rd x unsigned Rr, 3 as 0 |
| frac_i | input | 1 | 1 selects the fractional result (product shifted left by one) |
| rd_i | input | 8 | First operand, the signed one in mixed mode |
| rr_i | input | 8 | Second operand |
| prod_o | output | 16 | Result; bits 15:8 go to the high register of the pair, bits 7:0 to the low one |
| z_o | output | 1 | Zero flag value for the result |
| c_o | output | 1 | Carry flag value for the result |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest case to reach from the ports is a start that arrives while the block is busy. That start has to be high exactly in the cycle between an accepted start and its done pulse, with operands that would produce a different result. The stimulus holds the strobe high for two consecutive cycles and changes the operands and mode in the second cycle. It then checks that one done pulse appears, that the result belongs to the first request, and that no pulse follows in the next cycle. The signed corner -128 x -128 is also driven in integer and fractional form, to show the wrap without saturation and the carry taken from the unshifted product.

// File: rtl/mulfx_pkg.sv
package mulfx_pkg;

    typedef enum logic [1:0] {
        MODE_UNS_UNS = 2'd0,
        MODE_SGN_SGN = 2'd1,
        MODE_SGN_UNS = 2'd2,
        MODE_ALIAS_U = 2'd3
    } mul_mode_e;

    // Rd is signed in the fully signed and the mixed mode
    function automatic logic rd_is_signed(input logic [1:0] mode);
        return (mode == MODE_SGN_SGN) || (mode == MODE_SGN_UNS);
    endfunction

    // Rr is signed only in the fully signed mode
    function automatic logic rr_is_signed(input logic [1:0] mode);
        return (mode == MODE_SGN_SGN);
    endfunction

endpackage

// File: rtl/mulfx_extend.sv
// Widens an operand by one bit, with sign or zero fill.
module mulfx_extend #(
    parameter int unsigned W = 8
) (
    input  logic         sgn_i,
    input  logic [W-1:0] val_i,
    output logic [W:0]   ext_o
);
    always_comb begin
        ext_o = {sgn_i & val_i[W-1], val_i};
    end
endmodule

// File: rtl/mulfx_core.sv
// Signed multiply of widened operands, fractional scaling and flag values.
module mulfx_core #(
    parameter int unsigned W = 8
) (
    input  logic [W:0]     a_i,
    input  logic [W:0]     b_i,
    input  logic           frac_i,
    output logic [2*W-1:0] res_o,
    output logic           z_o,
    output logic           c_o
);
    localparam int unsigned PW   = 2 * W;
    localparam int unsigned FULL = 2 * W + 2;

    logic signed [FULL-1:0] full_p;
    logic        [PW-1:0]   raw_p;

    always_comb begin
        full_p = $signed(a_i) * $signed(b_i);
        raw_p  = full_p[PW-1:0];
        c_o    = raw_p[PW-1];
        res_o  = frac_i ? {raw_p[PW-2:0], 1'b0} : raw_p;
        z_o    = (res_o == '0);
    end
endmodule

// File: rtl/mul8_frac_unit.sv
module mul8_frac_unit #(
    parameter int unsigned OP_W = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [1:0]           mode_i,
    input  logic                 frac_i,
    input  logic [OP_W-1:0]      rd_i,
    input  logic [OP_W-1:0]      rr_i,
    output logic [2*OP_W-1:0]    prod_o,
    output logic                 z_o,
    output logic                 c_o,
    output logic                 done_o
);
    import mulfx_pkg::*;

    localparam int unsigned PW = 2 * OP_W;
    localparam int unsigned XW = OP_W + 1;
    localparam int unsigned NOPS = 2;

    typedef struct packed {
        logic          s1_vld;
        logic [XW-1:0] a_ext;
        logic [XW-1:0] b_ext;
        logic          frac;
        logic [PW-1:0] prod;
        logic          z;
        logic          c;
        logic          done;
    } mul_state_t;

    mul_state_t st_d, st_q;

    logic [OP_W-1:0] op_raw [NOPS];
    logic            op_sgn [NOPS];
    logic [XW-1:0]   op_ext [NOPS];

    always_comb begin
        op_raw[0] = rd_i;
        op_raw[1] = rr_i;
        op_sgn[0] = rd_is_signed(mode_i);
        op_sgn[1] = rr_is_signed(mode_i);
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_ext
        mulfx_extend #(.W(OP_W)) u_ext (
            .sgn_i (op_sgn[g]),
            .val_i (op_raw[g]),
            .ext_o (op_ext[g])
        );
    end

    logic [PW-1:0] core_res;
    logic          core_z;
    logic          core_c;

    mulfx_core #(.W(OP_W)) u_core (
        .a_i    (st_q.a_ext),
        .b_i    (st_q.b_ext),
        .frac_i (st_q.frac),
        .res_o  (core_res),
        .z_o    (core_z),
        .c_o    (core_c)
    );

    logic accept;

    always_comb begin
        st_d   = st_q;
        accept = start_i && !st_q.s1_vld;

        st_d.s1_vld = accept;
        if (accept) begin
            st_d.a_ext = op_ext[0];
            st_d.b_ext = op_ext[1];
            st_d.frac  = frac_i;
        end

        st_d.done = st_q.s1_vld;
        if (st_q.s1_vld) begin
            st_d.prod = core_res;
            st_d.z    = core_z;
            st_d.c    = core_c;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod_o = st_q.prod;
    assign z_o    = st_q.z;
    assign c_o    = st_q.c;
    assign done_o = st_q.done;

endmodule

// File: rtl/mulfx_checker.sv
module mulfx_checker #(
    parameter int unsigned OP_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              frac_i,
    input logic [2*OP_W-1:0] prod_o,
    input logic              z_o,
    input logic              c_o,
    input logic              done_o
);
    // R8
    done_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(start_i, 2));

    // R9
    single_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (z_o == (prod_o == '0)));

    // R5
    frac_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && $past(frac_i, 2)) |-> !prod_o[0]);

    // R10
    hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(prod_o) && $stable(z_o) && $stable(c_o)));
endmodule

bind mul8_frac_unit mulfx_checker #(.OP_W(OP_W)) u_mulfx_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .frac_i  (frac_i),
    .prod_o  (prod_o),
    .z_o     (z_o),
    .c_o     (c_o),
    .done_o  (done_o)
);

// File: tb/mul8_frac_unit_bench.sv
module mul8_frac_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        frac = 1'b0;
    logic [7:0]  rd = 8'd0;
    logic [7:0]  rr = 8'd0;
    logic [15:0] prod;
    logic        z, c, done;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mul8_frac_unit u_mul8_frac_unit (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
        .frac_i(frac), .rd_i(rd), .rr_i(rr),
        .prod_o(prod), .z_o(z), .c_o(c), .done_o(done)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%h expected=0x%h", req, what, act, exp);
        end
    endtask

    // Reference from the requirements: widen per mode, multiply, keep 16 bits
    task automatic model(input logic [1:0] m, input logic f, input logic [7:0] a,
                         input logic [7:0] b, output logic [15:0] res,
                         output logic zz, output logic cc);
        int av, bv, p;
        logic [15:0] raw;
        av = (m == 2'd1 || m == 2'd2) ? int'($signed(a)) : int'(a);
        bv = (m == 2'd1) ? int'($signed(b)) : int'(b);
        p = av * bv;
        raw = p[15:0];
        cc = raw[15];
        res = f ? {raw[14:0], 1'b0} : raw;
        zz = (res == 16'h0);
    endtask

    // Issue one operation and check done timing, result and flags
    task automatic run_op(input string req, input logic [1:0] m, input logic f,
                          input logic [7:0] a, input logic [7:0] b);
        logic [15:0] er;
        logic ez, ec;
        model(m, f, a, b, er, ez, ec);
        start = 1'b1; mode = m; frac = f; rd = a; rr = b;
        @(negedge clk);
        start = 1'b0;
        check("R8", "done one cycle after start", {15'd0, done}, 16'd0);
        @(negedge clk);
        check("R8", "done two cycles after start", {15'd0, done}, 16'd1);
        check(req, "product", prod, er);
        check("R6", "carry", {15'd0, c}, {15'd0, ec});
        check("R7", "zero", {15'd0, z}, {15'd0, ez});
        @(negedge clk);
        check("R8", "done lasts one cycle", {15'd0, done}, 16'd0);
        check("R10", "product held", prod, er);
    endtask

    task automatic test_reset();
        check("R11", "reset product", prod, 16'h0);
        check("R11", "reset flags", {14'd0, z, c}, 16'd0);
        check("R11", "reset done", {15'd0, done}, 16'd0);
    endtask

    task automatic test_unsigned();
        run_op("R1", 2'd0, 1'b0, 8'hFF, 8'hFF);
        check("R1", "0xFF*0xFF literal", prod, 16'hFE01);
        run_op("R1", 2'd0, 1'b0, 8'h12, 8'h34);
        run_op("R1", 2'd0, 1'b0, 8'h00, 8'hA5);
        check("R7", "zero product sets z", {15'd0, z}, 16'd1);
    endtask

    task automatic test_signed();
        run_op("R2", 2'd1, 1'b0, 8'h80, 8'h80);
        check("R2", "-128*-128 literal", prod, 16'h4000);
        run_op("R2", 2'd1, 1'b0, 8'hFE, 8'h05);
        run_op("R2", 2'd1, 1'b0, 8'h7F, 8'h81);
    endtask

    task automatic test_mixed();
        run_op("R3", 2'd2, 1'b0, 8'hFF, 8'hFF);
        check("R3", "-1*255 literal", prod, 16'hFF01);
        run_op("R3", 2'd2, 1'b0, 8'h40, 8'hC8);
        run_op("R4", 2'd3, 1'b0, 8'hFF, 8'h80);
        check("R4", "mode 3 as unsigned", prod, 16'h7F80);
    endtask

    task automatic test_fraction();
        run_op("R5", 2'd1, 1'b1, 8'h80, 8'h80);
        check("R5", "signed frac wrap", prod, 16'h8000);
        check("R6", "carry from unshifted", {15'd0, c}, 16'd0);
        run_op("R5", 2'd0, 1'b1, 8'hFF, 8'hFF);
        check("R6", "carry from unshifted set", {15'd0, c}, 16'd1);
        run_op("R5", 2'd2, 1'b1, 8'hC0, 8'h40);
        run_op("R5", 2'd1, 1'b1, 8'h00, 8'h55);
    endtask

    task automatic test_busy();
        logic [15:0] er;
        logic ez, ec;
        model(2'd0, 1'b0, 8'h03, 8'h07, er, ez, ec);
        start = 1'b1; mode = 2'd0; frac = 1'b0; rd = 8'h03; rr = 8'h07;
        @(negedge clk);
        mode = 2'd1; frac = 1'b1; rd = 8'h90; rr = 8'hEE;
        @(negedge clk);
        start = 1'b0;
        check("R9", "first request completes", {15'd0, done}, 16'd1);
        check("R9", "result of first request", prod, er);
        @(negedge clk);
        check("R9", "no done for dropped start", {15'd0, done}, 16'd0);
        check("R9", "result not overwritten", prod, er);
        @(negedge clk);
        check("R9", "still no done", {15'd0, done}, 16'd0);
        check("R10", "flags held", {14'd0, z, c}, {14'd0, ez, ec});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_unsigned();
        test_signed();
        test_mixed();
        test_fraction();
        test_busy();
        run_op("R1", 2'd0, 1'b0, 8'h0F, 8'h10);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule